// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a small stored-program processor built around one accumulator. It has three architectural registers: the accumulator, a program counter and an instruction register. One internal word-addressed RAM holds both code and data. For each instruction the core reads the word at the program counter into the instruction register, advances the program counter, and then carries out the operation. It repeats this until it meets a stop instruction.

The surrounding logic (in practice a testbench) fills the RAM through a side port while the core is idle, and then pulses `start`. It waits for `halted` and reads the results back through the same port. Opcodes 0 to 10 form the instruction set. Every higher opcode stops the core and raises `illegal`.

Top module: `acc_cpu`

## Requirements
- R1: When `rst` is high on a clock edge, the program counter becomes 1, the accumulator becomes 0, and `halted` and `illegal` become 0. The core then stays idle and runs no instruction until `start` is seen high.
- R2: Each instruction takes exactly three clock edges: read the word at the program counter, load the instruction register and add one to the program counter, then execute. If `start` is sampled at edge E and the n-th instruction stops the core, `halted` is first high after edge E+3n.
- R3: An instruction word is 24 bits wide. Bits [23:16] hold the opcode and bits [15:0] hold the operand. Any address formed from the operand, whether a data address or a jump target, uses only its low 10 bits, which means modulo 1024.
- R4: Opcode 1 loads the accumulator from RAM at the operand address. Opcode 2 loads the operand itself, zero-extended to 24 bits.
- R5: Opcode 3 writes the accumulator into RAM at the operand address.
- R6: Opcode 4 adds the RAM word at the operand address and opcode 5 adds the zero-extended operand. Opcode 6 subtracts the RAM word and opcode 7 subtracts the zero-extended operand. All four wrap modulo 2^24.
- R7: Opcode 8 always loads the program counter with the operand. Opcode 9 does so only when the accumulator is zero. Opcode 10 does so only when the accumulator, read as a signed two's-complement value, is greater than zero. A jump that is not taken continues at the next sequential word.
- R8: Opcode 0 stops the core with `halted` high and `illegal` low. `halted` stays high until reset, and `start` has no effect while the core is stopped.
- R9: Opcodes 11 to 255 stop the core in the same way as opcode 0, but also raise `illegal`. `illegal` stays high until reset.
- R10: While the core is idle or stopped, `tb_we` high writes `tb_wdata` to RAM at `tb_addr`. `tb_rdata` shows the word at the `tb_addr` presented one edge earlier. While the core is running, `tb_we` is ignored and RAM contents are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins execution from the idle state |
| tb_we | input | 1 | Side-port write enable (idle or stopped only) |
| tb_addr | input | 10 | Side-port word address |
| tb_wdata | input | 24 | Side-port write data |
| tb_rdata | output | 24 | Side-port read data, one edge after the address |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an undefined opcode |

## Verification
The reference model advances one phase per rising edge. It retires an instruction on every third edge after the start edge, so `halted` and `illegal` become due on edge 3n, and the bench compares them against the model at every falling edge. Side-port reads are set up at one falling edge and checked at the next one, after the single registered RAM read. Jump, wrap, sign and ignored-write cases can be seen only through when the core halts and what the RAM holds afterwards. For that reason, every data location the programs touch is read back and compared with the model's memory once `halted` rises.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
    localparam int OPC_W    = 8;
    localparam int OPD_W    = 16;
    localparam int WORD_W   = OPC_W + OPD_W;
    localparam int LAST_OPC = 10;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 8'd0,
        OP_LOAD  = 8'd1,
        OP_LOADI = 8'd2,
        OP_STORE = 8'd3,
        OP_ADD   = 8'd4,
        OP_ADDI  = 8'd5,
        OP_SUB   = 8'd6,
        OP_SUBI  = 8'd7,
        OP_JMP   = 8'd8,
        OP_JZ    = 8'd9,
        OP_JPOS  = 8'd10
    } opcode_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [OPD_W-1:0] opd;
    } instr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_STOP
    } phase_e;

    function automatic logic opc_defined(input logic [OPC_W-1:0] opc);
        return opc <= OPC_W'(LAST_OPC);
    endfunction

    function automatic logic [WORD_W-1:0] widen(input logic [OPD_W-1:0] opd);
        return {{(WORD_W-OPD_W){1'b0}}, opd};
    endfunction
endpackage

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram
    import acc_cpu_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end
endmodule

// File: rtl/acc_cpu_exec.sv
module acc_cpu_exec
    import acc_cpu_pkg::*;
#(
    parameter int AW = 10
) (
    input  instr_t            ir,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] mem_val,
    input  logic [AW-1:0]     pc,
    output logic [WORD_W-1:0] acc_nx,
    output logic [AW-1:0]     pc_nx,
    output logic              st_we,
    output logic              stop,
    output logic              bad
);
    logic [WORD_W-1:0] imm;
    logic [AW-1:0]     tgt;

    always_comb begin
        imm    = widen(ir.opd);
        tgt    = ir.opd[AW-1:0];
        acc_nx = acc;
        pc_nx  = pc;
        st_we  = 1'b0;
        stop   = 1'b0;
        bad    = 1'b0;
        if (!opc_defined(ir.opc)) begin
            stop = 1'b1;
            bad  = 1'b1;
        end else begin
            case (ir.opc)
                OP_HALT:  stop   = 1'b1;
                OP_LOAD:  acc_nx = mem_val;
                OP_LOADI: acc_nx = imm;
                OP_STORE: st_we  = 1'b1;
                OP_ADD:   acc_nx = acc + mem_val;
                OP_ADDI:  acc_nx = acc + imm;
                OP_SUB:   acc_nx = acc - mem_val;
                OP_SUBI:  acc_nx = acc - imm;
                OP_JMP:   pc_nx  = tgt;
                OP_JZ:    if (acc == '0) pc_nx = tgt;
                OP_JPOS:  if ($signed(acc) > 0) pc_nx = tgt;
                default: begin
                    stop = 1'b1;
                    bad  = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [AW-1:0]     core_addr,
    output logic              core_we,
    output logic [WORD_W-1:0] core_wdata,
    output logic              busy,
    output logic              halted,
    output logic              illegal
);
    localparam logic [AW-1:0] PC_RESET = AW'(1);

    phase_e            state;
    instr_t            ir;
    instr_t            fetched;
    logic [AW-1:0]     pc;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] acc_nx;
    logic [AW-1:0]     pc_nx;
    logic              st_we;
    logic              stop;
    logic              bad;

    assign fetched = instr_t'(mem_rdata);

    acc_cpu_exec #(.AW(AW)) u_exec (
        .ir      (ir),
        .acc     (acc),
        .mem_val (mem_rdata),
        .pc      (pc),
        .acc_nx  (acc_nx),
        .pc_nx   (pc_nx),
        .st_we   (st_we),
        .stop    (stop),
        .bad     (bad)
    );

    always_comb begin
        core_addr  = '0;
        core_we    = 1'b0;
        core_wdata = acc;
        case (state)
            ST_FETCH:  core_addr = pc;
            ST_DECODE: core_addr = fetched.opd[AW-1:0];
            ST_EXEC: begin
                core_addr = ir.opd[AW-1:0];
                core_we   = st_we;
            end
            default:   core_addr = '0;
        endcase
    end

    assign busy = (state == ST_FETCH) || (state == ST_DECODE) || (state == ST_EXEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pc      <= PC_RESET;
            acc     <= '0;
            ir      <= '0;
            halted  <= 1'b0;
            illegal <= 1'b0;
        end else begin
            case (state)
                ST_IDLE:   if (start) state <= ST_FETCH;
                ST_FETCH:  state <= ST_DECODE;
                ST_DECODE: begin
                    ir    <= fetched;
                    pc    <= pc + 1'b1;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    acc <= acc_nx;
                    pc  <= pc_nx;
                    if (stop) begin
                        state   <= ST_STOP;
                        halted  <= 1'b1;
                        illegal <= bad;
                    end else begin
                        state <= ST_FETCH;
                    end
                end
                default:   state <= ST_STOP;
            endcase
        end
    end

    assert_reset_regs_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == PC_RESET && acc == '0 && !halted));

    assert_pc_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE) |=> (pc == $past(pc) + 1'b1));

    assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && ir.opc == OP_JMP) |=> (pc == $past(ir.opd[AW-1:0])));

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_illegal_halts_R9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int MEM_DEPTH = 1024,
    localparam int AW       = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              tb_we,
    input  logic [AW-1:0]     tb_addr,
    input  logic [WORD_W-1:0] tb_wdata,
    output logic [WORD_W-1:0] tb_rdata,
    output logic              halted,
    output logic              illegal
);
    logic [AW-1:0]     core_addr;
    logic              core_we;
    logic [WORD_W-1:0] core_wdata;
    logic              busy;
    logic [AW-1:0]     ram_addr;
    logic              ram_we;
    logic [WORD_W-1:0] ram_wdata;
    logic [WORD_W-1:0] ram_rdata;

    assign ram_addr  = busy ? core_addr  : tb_addr;
    assign ram_we    = busy ? core_we    : tb_we;
    assign ram_wdata = busy ? core_wdata : tb_wdata;
    assign tb_rdata  = ram_rdata;

    acc_cpu_ram #(.DEPTH(MEM_DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    acc_cpu_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mem_rdata  (ram_rdata),
        .core_addr  (core_addr),
        .core_we    (core_we),
        .core_wdata (core_wdata),
        .busy       (busy),
        .halted     (halted),
        .illegal    (illegal)
    );

    assert_side_write_blocked_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && tb_we && !core_we) |-> !ram_we);
endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
    localparam int AW   = 10;
    localparam int DEP  = 1024;
    localparam int WDOG = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        tb_we = 1'b0;
    logic [9:0]  tb_addr = '0;
    logic [23:0] tb_wdata = '0;
    logic [23:0] tb_rdata;
    logic        halted;
    logic        illegal;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    acc_cpu uut (
        .clk(clk), .rst(rst), .start(start), .tb_we(tb_we), .tb_addr(tb_addr),
        .tb_wdata(tb_wdata), .tb_rdata(tb_rdata), .halted(halted), .illegal(illegal)
    );

    // behavioural reference model
    logic [23:0] m_mem [DEP];
    int          m_pc;
    logic [23:0] m_acc;
    bit          m_run, m_halt, m_ill;
    int          m_phase;

    task automatic model_exec();
        logic [23:0] w;
        int op, opd, a;
        w   = m_mem[m_pc];
        op  = int'(w[23:16]);
        opd = int'(w[15:0]);
        a   = opd % DEP;
        m_pc = (m_pc + 1) % DEP;
        if (op == 0 || op > 10) begin
            m_run = 0; m_halt = 1; m_ill = (op > 10);
        end else if (op == 1) m_acc = m_mem[a];
        else if (op == 2) m_acc = 24'(opd);
        else if (op == 3) m_mem[a] = m_acc;
        else if (op == 4) m_acc = m_acc + m_mem[a];
        else if (op == 5) m_acc = m_acc + 24'(opd);
        else if (op == 6) m_acc = m_acc - m_mem[a];
        else if (op == 7) m_acc = m_acc - 24'(opd);
        else if (op == 8) m_pc = a;
        else if (op == 9) begin if (m_acc == 0) m_pc = a; end
        else begin if ($signed(m_acc) > 0) m_pc = a; end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_pc = 1; m_acc = '0; m_run = 0; m_halt = 0; m_ill = 0; m_phase = 0;
        end else if (m_run) begin
            m_phase = m_phase + 1;
            if (m_phase == 3) begin
                m_phase = 0;
                model_exec();
            end
        end else begin
            if (tb_we) m_mem[tb_addr] = tb_wdata;
            if (start && !m_halt) begin
                m_run = 1; m_phase = 0;
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (halted !== m_halt) begin
                fails++;
                $display("FAIL %s halted act=%0d exp=%0d t=%0t", cur_req, halted, m_halt, $time);
            end
            checks++;
            if (illegal !== m_ill) begin
                fails++;
                $display("FAIL %s illegal act=%0d exp=%0d t=%0t", cur_req, illegal, m_ill, $time);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog act=%0d cycles exp=<%0d", cycles, WDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    function automatic logic [23:0] ins(input int op, input int opd);
        return {8'(op), 16'(opd)};
    endfunction

    task automatic wr(input int a, input logic [23:0] d);
        tb_we = 1'b1; tb_addr = 10'(a); tb_wdata = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic rd(input int a, input string req);
        tb_addr = 10'(a);
        @(negedge clk);
        checks++;
        if (tb_rdata !== m_mem[a]) begin
            fails++;
            $display("FAIL %s mem[%0d] act=%h exp=%h", req, a, tb_rdata, m_mem[a]);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int poke_at);
        int n;
        n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_halt && n < 20000) begin
            if (n == poke_at) wr(30, 24'h000555);
            else @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1: idle after reset, nothing runs without start
        cur_req = "R1 idle";
        repeat (6) @(negedge clk);

        // Program A: multiply by repeated addition (R2 R4 R5 R6 R7 R8)
        wr(0, ins(12, 0));            // R1: a pc of 0 would trip illegal
        wr(1, ins(1, 1000));
        wr(2, ins(3, 1003));
        wr(3, ins(2, 0));
        wr(4, ins(3, 1002));
        wr(5, ins(1, 1003));
        wr(6, ins(9, 13));
        wr(7, ins(7, 1));
        wr(8, ins(3, 1003));
        wr(9, ins(1, 1002));
        wr(10, ins(4, 1001));
        wr(11, ins(3, 1002));
        wr(12, ins(8, 5));
        wr(13, ins(0, 0));
        wr(1000, 24'd7);
        wr(1001, 24'd6);
        cur_req = "R2 R8 multiply";
        run(-1);
        rd(1002, "R4 R5 R6 product");
        rd(1003, "R7 loop counter");
        // R8: start after halt is ignored
        cur_req = "R8 restart ignored";
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        rd(1002, "R8 no rerun");

        // Program B: signs, not-taken jumps, wrap, illegal (R3 R6 R7 R9 R10)
        do_reset();
        cur_req = "R1 second reset";
        wr(20, 24'd9);
        wr(21, 24'd100);
        wr(30, 24'd7);
        wr(1, ins(2, 5));
        wr(2, ins(6, 20));
        wr(3, ins(10, 9));
        wr(4, ins(9, 9));
        wr(5, ins(5, 4));
        wr(6, ins(9, 8));
        wr(7, ins(0, 0));
        wr(8, ins(4, 1024 + 21));
        wr(9, ins(10, 11));
        wr(10, ins(0, 0));
        wr(11, ins(3, 22));
        wr(12, ins(7, 101));
        wr(13, ins(3, 1024 + 23));
        wr(14, ins(12, 0));
        cur_req = "R7 R9 branch and illegal";
        run(4);
        rd(22, "R3 R6 wrapped add");
        rd(23, "R6 negative store");
        rd(30, "R10 write while running ignored");

        // Program C: bare halt, then side-port write after stop (R8 R10)
        do_reset();
        wr(1, ins(0, 0));
        cur_req = "R8 plain halt";
        run(-1);
        wr(40, 24'hABCDEF);
        rd(40, "R10 write after halt");
        rd(1, "R10 program word");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule